// File: doc/BRIEF.md
# Two-Wide Register Rename Unit

This block sits at the dispatch stage of an out-of-order core. Each cycle it accepts a group of up to two instructions, given in program order with slot 0 as the older one. It translates their architectural source and destination names into physical register tags. It keeps two structures: a map table, indexed by architectural register, that holds the current physical tag for each name, and a circular FIFO of free physical tags. Each instruction that writes a register takes a tag from the head of that FIFO. The tag the destination held before is passed downstream as the register to release. The commit stage sends such tags back through a two-entry return port once the overwriting instruction retires, because no older reader can still need them at that point.

The younger slot sees the older slot's effects within the same group. If it reads a register the older slot writes, it gets the older slot's fresh tag. If it writes the same register, its release tag is also the older slot's fresh tag. A small controller tracks how full the free list is, using three named states: `FL_OPEN` (two or more free tags), `FL_LOW` (one free tag) and `FL_EMPTY` (no free tag). The controller holds dispatch off when a group asks for more tags than are free. The state is re-evaluated every cycle from the next free count, so any state can move to any other state in one cycle. Allocations and returns drive the transitions: `FL_OPEN`→`FL_LOW`, `FL_OPEN`→`FL_EMPTY`, `FL_LOW`→`FL_EMPTY`, `FL_LOW`→`FL_OPEN`, `FL_EMPTY`→`FL_LOW` and `FL_EMPTY`→`FL_OPEN`. Only reset restores the initial mapping.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural index k (0-based, k = 0 is r1) maps to physical index ARCH_REGS-1-k, and the free FIFO holds physical indices ARCH_REGS..PHYS_REGS-1 in ascending order, oldest first.
- R2: A slot's source tags are the mappings that were in force before that slot's own destination update, so an instruction that reads and writes the same register gets the old tag.
- R3: `ren_free` for a slot that writes is the physical tag its destination was mapped to before the group.
- R4: Fresh destination tags leave the free FIFO in FIFO order, and slot 0 takes the older entry when both slots allocate.
- R5: When slot 1 reads a register that slot 0 of the same accepted group writes, slot 1's source tag is slot 0's fresh tag.
- R6: When both slots of an accepted group write the same architectural register, slot 1's `ren_free` is slot 0's fresh tag, and the map keeps slot 1's tag.
- R7: A slot with `dis_dst_en` low allocates nothing, leaves the map unchanged, and has `ren_dst_en` low.
- R8: `dis_ready` is high exactly when the free count is at least the number of valid slots with `dis_dst_en` set. When a group is offered with `dis_ready` low, it changes no state and produces no output.
- R9: Tags presented on `ret_valid`/`ret_tag` are appended to the FIFO tail, slot 0 before slot 1, and count as free from the next cycle on.
- R10: In the cycle renamed results appear, `clr_ready_mask` has one bit set per freshly allocated tag, at bit position equal to that tag, and no other bits.
- R11: Results are registered. `ren_valid` rises for the accepted slots in the cycle after acceptance and is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, restores the initial mapping |
| dis_valid | input | 2 | Slot valid; slot 0 is older |
| dis_src_a | input | 2 x AW | First source architectural index per slot |
| dis_src_b | input | 2 x AW | Second source architectural index per slot |
| dis_dst_en | input | 2 | Slot writes a destination |
| dis_dst | input | 2 x AW | Destination architectural index per slot |
| dis_ready | output | 1 | Group can be accepted this cycle |
| ret_valid | input | 2 | Commit returns a tag on this lane |
| ret_tag | input | 2 x PW | Physical tags returned by commit |
| ren_valid | output | 2 | Renamed slot valid |
| ren_src_a | output | 2 x PW | Physical tag of first source |
| ren_src_b | output | 2 x PW | Physical tag of second source |
| ren_dst_en | output | 2 | Renamed slot has a fresh destination |
| ren_dst | output | 2 x PW | Fresh physical destination tag |
| ren_free | output | 2 x PW | Prior mapping to release at commit |
| clr_ready_mask | output | PHYS_REGS | One bit per freshly allocated tag, for the scheduler |

## Verification
On every cycle the assertions check several properties. Output appears only after an accepted group, and stalled or empty groups produce nothing. The two fresh tags of a pair differ. The clear-ready mask carries exactly as many bits as there are allocations. Both in-group bypasses, for a source and for the release tag, pick up slot 0's fresh tag. Other behaviour needs a reference map and queue that persist across many groups, so only the bench's scenarios can show it. That covers the reset mapping, the use of old tags when an instruction reads its own destination, the FIFO order of allocation after tags come back from commit, and the exact tag values.

// File: rtl/rename_pkg.sv
package rename_pkg;
    localparam int SLOTS = 2;

    typedef enum logic [1:0] {
        FL_OPEN  = 2'd0,
        FL_LOW   = 2'd1,
        FL_EMPTY = 2'd2
    } fl_state_e;
endpackage

// File: rtl/rename_map.sv
module rename_map #(
    parameter int ARCH_REGS = 8,
    parameter int PHYS_REGS = 12,
    parameter int NRD       = 6,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int PW = $clog2(PHYS_REGS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NRD-1:0][AW-1:0]  rd_idx,
    output logic [NRD-1:0][PW-1:0]  rd_tag,
    input  logic [1:0]              wr_en,
    input  logic [1:0][AW-1:0]      wr_idx,
    input  logic [1:0][PW-1:0]      wr_tag
);
    logic [PW-1:0] map_q [ARCH_REGS];

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_tag[r] = map_q[rd_idx[r]];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < ARCH_REGS; k++) begin
                map_q[k] <= PW'(ARCH_REGS - 1 - k);
            end
        end else begin
            // younger slot written last so it wins on a shared index
            if (wr_en[0]) map_q[wr_idx[0]] <= wr_tag[0];
            if (wr_en[1]) map_q[wr_idx[1]] <= wr_tag[1];
        end
    end
endmodule

// File: rtl/rename_freelist.sv
module rename_freelist #(
    parameter int ARCH_REGS = 8,
    parameter int PHYS_REGS = 12,
    localparam int PW    = $clog2(PHYS_REGS),
    localparam int CW    = $clog2(PHYS_REGS + 1),
    localparam int FREE0 = PHYS_REGS - ARCH_REGS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop0,
    input  logic          pop1,
    output logic [PW-1:0] tag0,
    output logic [PW-1:0] tag1,
    input  logic          push0,
    input  logic          push1,
    input  logic [PW-1:0] ptag0,
    input  logic [PW-1:0] ptag1,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cnt_nx
);
    logic [PW-1:0] fl_q [PHYS_REGS];
    logic [PW-1:0] head_q, tail_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p, input logic inc);
        int s;
        s = int'(p) + (inc ? 1 : 0);
        if (s >= PHYS_REGS) s = s - PHYS_REGS;
        return PW'(s);
    endfunction

    function automatic logic [PW-1:0] step2(input logic [PW-1:0] p, input logic a, input logic b);
        return step(step(p, a), b);
    endfunction

    assign tag0   = fl_q[head_q];
    assign tag1   = fl_q[step(head_q, pop0)];
    assign cnt    = cnt_q;
    assign cnt_nx = cnt_q - CW'(pop0) - CW'(pop1) + CW'(push0) + CW'(push1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PHYS_REGS; i++) begin
                fl_q[i] <= (i < FREE0) ? PW'(ARCH_REGS + i) : '0;
            end
            head_q <= '0;
            tail_q <= PW'(FREE0);
            cnt_q  <= CW'(FREE0);
        end else begin
            if (push0) fl_q[tail_q] <= ptag0;
            if (push1) fl_q[step(tail_q, push0)] <= ptag1;
            head_q <= step2(head_q, pop0, pop1);
            tail_q <= step2(tail_q, push0, push1);
            cnt_q  <= cnt_nx;
        end
    end
endmodule

// File: rtl/rename_ctrl.sv
module rename_ctrl
    import rename_pkg::*;
#(
    parameter int ARCH_REGS = 8,
    parameter int PHYS_REGS = 12,
    localparam int CW    = $clog2(PHYS_REGS + 1),
    localparam int FREE0 = PHYS_REGS - ARCH_REGS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_nx,
    input  logic [1:0]    need,
    output logic          ready,
    output fl_state_e     state
);
    fl_state_e state_q, state_nx;

    function automatic fl_state_e classify(input int c);
        if (c >= 2)      return FL_OPEN;
        else if (c == 1) return FL_LOW;
        else             return FL_EMPTY;
    endfunction

    always_comb begin
        state_nx = classify(int'(cnt_nx));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= classify(FREE0);
        else        state_q <= state_nx;
    end

    always_comb begin
        ready = 1'b0;
        unique case (state_q)
            FL_OPEN:  ready = 1'b1;
            FL_LOW:   ready = (need <= 2'd1);
            FL_EMPTY: ready = (need == 2'd0);
            default:  ready = 1'b0;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/rename_unit.sv
module rename_unit
    import rename_pkg::*;
#(
    parameter int ARCH_REGS = 8,
    parameter int PHYS_REGS = 12,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int PW = $clog2(PHYS_REGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           dis_valid,
    input  logic [1:0][AW-1:0]   dis_src_a,
    input  logic [1:0][AW-1:0]   dis_src_b,
    input  logic [1:0]           dis_dst_en,
    input  logic [1:0][AW-1:0]   dis_dst,
    output logic                 dis_ready,
    input  logic [1:0]           ret_valid,
    input  logic [1:0][PW-1:0]   ret_tag,
    output logic [1:0]           ren_valid,
    output logic [1:0][PW-1:0]   ren_src_a,
    output logic [1:0][PW-1:0]   ren_src_b,
    output logic [1:0]           ren_dst_en,
    output logic [1:0][PW-1:0]   ren_dst,
    output logic [1:0][PW-1:0]   ren_free,
    output logic [PHYS_REGS-1:0] clr_ready_mask
);
    localparam int CW  = $clog2(PHYS_REGS + 1);
    localparam int NRD = 3 * SLOTS;

    logic [1:0]            wants, alloc;
    logic [1:0]            need;
    logic                  fire;
    logic [CW-1:0]         fl_cnt, fl_cnt_nx;
    logic [PW-1:0]         new0, new1;
    logic [NRD-1:0][AW-1:0] rd_idx;
    logic [NRD-1:0][PW-1:0] rd_tag;
    logic [1:0][PW-1:0]    src_a, src_b, prior, fresh;
    logic [PHYS_REGS-1:0]  mask_nx;
    fl_state_e             fl_state;

    assign wants = dis_valid & dis_dst_en;
    assign need  = {1'b0, wants[0]} + {1'b0, wants[1]};
    assign fire  = (|dis_valid) && dis_ready;
    assign alloc = fire ? wants : 2'b00;

    rename_ctrl #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cnt_nx(fl_cnt_nx), .need(need),
        .ready(dis_ready), .state(fl_state)
    );

    rename_freelist #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_free (
        .clk(clk), .rst_n(rst_n),
        .pop0(alloc[0]), .pop1(alloc[1]), .tag0(new0), .tag1(new1),
        .push0(ret_valid[0]), .push1(ret_valid[1]),
        .ptag0(ret_tag[0]), .ptag1(ret_tag[1]),
        .cnt(fl_cnt), .cnt_nx(fl_cnt_nx)
    );

    // read ports: per slot {src_a, src_b, dst}
    for (genvar s = 0; s < SLOTS; s++) begin : g_idx
        assign rd_idx[3*s]   = dis_src_a[s];
        assign rd_idx[3*s+1] = dis_src_b[s];
        assign rd_idx[3*s+2] = dis_dst[s];
    end

    rename_map #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS), .NRD(NRD)) u_map (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_tag(rd_tag),
        .wr_en(alloc), .wr_idx(dis_dst), .wr_tag(fresh)
    );

    always_comb begin
        fresh[0] = new0;
        fresh[1] = alloc[0] ? new1 : new0;
        // older slot: straight from the table
        src_a[0] = rd_tag[0];
        src_b[0] = rd_tag[1];
        prior[0] = rd_tag[2];
        // younger slot: bypass the older slot's fresh tag
        src_a[1] = (wants[0] && dis_dst[0] == dis_src_a[1]) ? new0 : rd_tag[3];
        src_b[1] = (wants[0] && dis_dst[0] == dis_src_b[1]) ? new0 : rd_tag[4];
        prior[1] = (wants[0] && dis_dst[0] == dis_dst[1])   ? new0 : rd_tag[5];
        mask_nx = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (alloc[s]) mask_nx[fresh[s]] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ren_valid      <= '0;
            ren_dst_en     <= '0;
            ren_src_a      <= '0;
            ren_src_b      <= '0;
            ren_dst        <= '0;
            ren_free       <= '0;
            clr_ready_mask <= '0;
        end else begin
            ren_valid      <= fire ? dis_valid : 2'b00;
            ren_dst_en     <= alloc;
            clr_ready_mask <= mask_nx;
            if (fire) begin
                ren_src_a <= src_a;
                ren_src_b <= src_b;
                ren_dst   <= fresh;
                ren_free  <= prior;
            end
        end
    end

    logic unused_ok;
    assign unused_ok = ^{fl_cnt, fl_state};
endmodule

// File: rtl/rename_unit_chk.sv
module rename_unit_chk #(
    parameter int ARCH_REGS = 8,
    parameter int PHYS_REGS = 12,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int PW = $clog2(PHYS_REGS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           dis_valid,
    input logic [1:0][AW-1:0]   dis_src_a,
    input logic [1:0]           dis_dst_en,
    input logic [1:0][AW-1:0]   dis_dst,
    input logic                 dis_ready,
    input logic [1:0]           ren_valid,
    input logic [1:0]           ren_dst_en,
    input logic [1:0][PW-1:0]   ren_src_a,
    input logic [1:0][PW-1:0]   ren_dst,
    input logic [1:0][PW-1:0]   ren_free,
    input logic [PHYS_REGS-1:0] clr_ready_mask
);
    logic fire;
    assign fire = (|dis_valid) && dis_ready;

    assert_stall_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|dis_valid) && !dis_ready) |=> (ren_valid == 2'b00));

    assert_idle_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_valid == 2'b00) |=> (ren_valid == 2'b00));

    assert_distinct_alloc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((ren_valid & ren_dst_en) == 2'b11) |-> (ren_dst[0] != ren_dst[1]));

    assert_mask_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(clr_ready_mask) == $countones(ren_valid & ren_dst_en));

    assert_dst_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((ren_dst_en & ~ren_valid) == 2'b00));

    assert_src_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && dis_valid == 2'b11 && dis_dst_en[0] && dis_dst[0] == dis_src_a[1])
        |=> (ren_src_a[1] == ren_dst[0]));

    assert_free_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && dis_valid == 2'b11 && dis_dst_en == 2'b11 && dis_dst[0] == dis_dst[1])
        |=> (ren_free[1] == ren_dst[0]));
endmodule

bind rename_unit rename_unit_chk #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_chk (
    .clk(clk), .rst_n(rst_n), .dis_valid(dis_valid), .dis_src_a(dis_src_a),
    .dis_dst_en(dis_dst_en), .dis_dst(dis_dst), .dis_ready(dis_ready),
    .ren_valid(ren_valid), .ren_dst_en(ren_dst_en), .ren_src_a(ren_src_a),
    .ren_dst(ren_dst), .ren_free(ren_free), .clr_ready_mask(clr_ready_mask)
);

// File: tb/rename_unit_test.sv
module rename_unit_test;
    localparam int ARCH = 8;
    localparam int PHYS = 12;
    localparam int AW = 3;
    localparam int PW = 4;
    localparam int NV = 10;

    // bit 22: return pending frees afterwards; [21:11] slot1, [10:0] slot0
    // slot: [10] valid, [9:7] src_a, [6:4] src_b, [3] dst_en, [2:0] dst
    localparam logic [22:0] VEC [NV] = '{
        {1'b1, 1'b1,3'd2,3'd7,1'b0,3'd0, 1'b1,3'd0,3'd1,1'b0,3'd0},
        {1'b1, 1'b1,3'd2,3'd5,1'b1,3'd4, 1'b1,3'd2,3'd3,1'b1,3'd2},
        {1'b1, 1'b1,3'd1,3'd0,1'b1,3'd1, 1'b1,3'd1,3'd6,1'b1,3'd1},
        {1'b0, 1'b0,3'd0,3'd0,1'b0,3'd0, 1'b1,3'd0,3'd4,1'b1,3'd0},
        {1'b0, 1'b1,3'd6,3'd3,1'b1,3'd6, 1'b0,3'd0,3'd0,1'b0,3'd0},
        {1'b0, 1'b1,3'd3,3'd5,1'b1,3'd5, 1'b1,3'd3,3'd0,1'b1,3'd3},
        {1'b0, 1'b0,3'd0,3'd0,1'b0,3'd0, 1'b1,3'd7,3'd2,1'b1,3'd7},
        {1'b1, 1'b1,3'd5,3'd6,1'b0,3'd0, 1'b1,3'd3,3'd0,1'b0,3'd0},
        {1'b1, 1'b1,3'd7,3'd7,1'b1,3'd7, 1'b1,3'd7,3'd1,1'b1,3'd7},
        {1'b1, 1'b1,3'd0,3'd0,1'b0,3'd0, 1'b1,3'd4,3'd0,1'b1,3'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0]          dis_valid = '0;
    logic [1:0][AW-1:0]  dis_src_a = '0;
    logic [1:0][AW-1:0]  dis_src_b = '0;
    logic [1:0]          dis_dst_en = '0;
    logic [1:0][AW-1:0]  dis_dst = '0;
    logic                dis_ready;
    logic [1:0]          ret_valid = '0;
    logic [1:0][PW-1:0]  ret_tag = '0;
    logic [1:0]          ren_valid;
    logic [1:0][PW-1:0]  ren_src_a, ren_src_b, ren_dst, ren_free;
    logic [1:0]          ren_dst_en;
    logic [PHYS-1:0]     clr_ready_mask;

    always #4 clk = ~clk;

    rename_unit uut (
        .clk(clk), .rst_n(rst_n), .dis_valid(dis_valid), .dis_src_a(dis_src_a),
        .dis_src_b(dis_src_b), .dis_dst_en(dis_dst_en), .dis_dst(dis_dst),
        .dis_ready(dis_ready), .ret_valid(ret_valid), .ret_tag(ret_tag),
        .ren_valid(ren_valid), .ren_src_a(ren_src_a), .ren_src_b(ren_src_b),
        .ren_dst_en(ren_dst_en), .ren_dst(ren_dst), .ren_free(ren_free),
        .clr_ready_mask(clr_ready_mask)
    );

    int n_chk = 0;
    int n_fail = 0;
    int mmap [ARCH];
    int fq [PHYS];
    int fq_head, fq_cnt;
    int pend [32];
    int pend_n;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic model_reset();
        for (int k = 0; k < ARCH; k++) mmap[k] = ARCH - 1 - k;
        for (int i = 0; i < PHYS; i++) fq[i] = (i < PHYS - ARCH) ? ARCH + i : 0;
        fq_head = 0;
        fq_cnt = PHYS - ARCH;
        pend_n = 0;
    endtask

    function automatic int model_pop();
        int t;
        t = fq[fq_head];
        fq_head = (fq_head + 1) % PHYS;
        fq_cnt--;
        return t;
    endfunction

    task automatic model_push(input int t);
        fq[(fq_head + fq_cnt) % PHYS] = t;
        fq_cnt++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        dis_valid = '0;
        ret_valid = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        #1;
        check("R1 ready after reset", int'(dis_ready), 1);
        check("R11 no output after reset", int'(ren_valid), 0);
        check("R10 mask clear after reset", int'(clr_ready_mask), 0);
    endtask

    task automatic run_group(input logic [22:0] vv);
        logic [1:0] v, e;
        int ea [2], eb [2], ed [2], ef [2];
        int need, exp_mask;
        bit exp_rdy;
        v = {vv[21], vv[10]};
        e = {vv[14], vv[3]};
        @(negedge clk);
        dis_valid = v;
        dis_src_a[0] = vv[9:7];  dis_src_b[0] = vv[6:4];  dis_dst_en[0] = vv[3];  dis_dst[0] = vv[2:0];
        dis_src_a[1] = vv[20:18]; dis_src_b[1] = vv[17:15]; dis_dst_en[1] = vv[14]; dis_dst[1] = vv[13:11];
        #1;
        need = int'(v[0] & e[0]) + int'(v[1] & e[1]);
        exp_rdy = (fq_cnt >= need);
        check("R8 ready vs free count", int'(dis_ready), int'(exp_rdy));
        exp_mask = 0;
        if (exp_rdy) begin
            for (int s = 0; s < 2; s++) begin
                if (v[s]) begin
                    ea[s] = mmap[int'(dis_src_a[s])];
                    eb[s] = mmap[int'(dis_src_b[s])];
                    if (e[s]) begin
                        ef[s] = mmap[int'(dis_dst[s])];
                        ed[s] = model_pop();
                        mmap[int'(dis_dst[s])] = ed[s];
                        exp_mask = exp_mask | (1 << ed[s]);
                    end
                end
            end
        end
        @(negedge clk);
        dis_valid = '0;
        dis_dst_en = '0;
        #1;
        if (!exp_rdy) begin
            check("R8 stalled group gives no output", int'(ren_valid), 0);
            check("R8 stalled group no mask", int'(clr_ready_mask), 0);
        end else begin
            check("R11 valid one cycle after accept", int'(ren_valid), int'(v));
            check("R10 clear-ready mask", int'(clr_ready_mask), exp_mask);
            for (int s = 0; s < 2; s++) begin
                if (v[s]) begin
                    check(s == 0 ? "R2 src_a" : "R5 src_a", int'(ren_src_a[s]), ea[s]);
                    check(s == 0 ? "R2 src_b" : "R5 src_b", int'(ren_src_b[s]), eb[s]);
                    check("R7 dst_en", int'(ren_dst_en[s]), int'(e[s]));
                    if (e[s]) begin
                        check("R4 R9 fresh tag", int'(ren_dst[s]), ed[s]);
                        check(s == 0 ? "R3 free tag" : "R6 free tag", int'(ren_free[s]), ef[s]);
                        pend[pend_n] = ef[s];
                        pend_n++;
                    end
                end
            end
        end
        if (vv[22]) begin
            for (int p = 0; p < pend_n; p += 2) begin
                ret_valid[0] = 1'b1;
                ret_tag[0] = PW'(pend[p]);
                model_push(pend[p]);
                if (p + 1 < pend_n) begin
                    ret_valid[1] = 1'b1;
                    ret_tag[1] = PW'(pend[p+1]);
                    model_push(pend[p+1]);
                end
                @(negedge clk);
                ret_valid = '0;
            end
            pend_n = 0;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        do_reset();
        for (int i = 0; i < NV; i++) run_group(VEC[i]);
        // R1: reset in mid-run restores the initial mapping and free order
        do_reset();
        run_group(VEC[0]);
        run_group(VEC[1]);
        repeat (2) @(negedge clk);
        finish_up();
    end
endmodule